// File: doc/BRIEF.md
# Page Access Fault Checker

This block sits after the address translation stage and decides whether a memory access may proceed. It samples an access strobe together with the access's virtual address, its direction (read or write), the current privilege level (0 to 3), and the combined present, writable and user attributes of the translated page. If the access breaks the page's rules, the block sends a fault request that carries exception vector 0x0E and a 32-bit error code. In the same cycle it records the faulting virtual address in a fault-address register.

Privilege level 3 runs in user mode, and levels 0 to 2 run in supervisor mode. A page that is not present always faults. A user-mode access to a page marked supervisor-only faults. A user-mode write to a page that is not writable faults. Supervisor code may write to read-only pages. Software reads the captured fault address through a small register read port. Pushing the exception onto a stack, dispatching the handler and editing page tables are handled elsewhere.

Top module: `pfc_top`

## Requirements
- R1: Privilege level 3 is user mode and levels 0 to 2 are supervisor mode. Error code bit 2 is 1 on a fault exactly when the faulting access was made at level 3.
- R2: A strobed access to a page that is not present faults, whatever its direction or privilege. Error code bit 0 is then 0.
- R3: A strobed user-mode write to a present page that is not writable faults. Error code bit 0 is then 1 and bit 1 is 1.
- R4: A strobed user-mode access, read or write, to a present page that is not user-accessible faults. Error code bit 0 is then 1.
- R5: A strobed access that meets none of the conditions in R2 to R4 does not fault. This covers supervisor writes to read-only pages and supervisor accesses to supervisor-only pages.
- R6: `flt_o` is high in the cycle after the strobe edge that sampled a faulting access. While it is high, `flt_vec_o` is 0x0E. Otherwise `flt_vec_o` is 0.
- R7: On a fault, error code bit 1 is 1 for a write and 0 for a read, and bits 31 to 3 are always 0.
- R8: The fault-address register resets to 0. It loads the faulting virtual address on the clock edge where `flt_o` is asserted, and it keeps its value on every other edge.
- R9: `flt_o` is high for one cycle for each faulting strobe. It is never high without a strobe on the previous edge. While `flt_o` is low, `flt_err_o` is 0.
- R10: The read port is combinational. `rd_addr_i` = 0 returns the fault-address register, and any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_vld_i | input | 1 | Access strobe |
| acc_va_i | input | 32 | Virtual address of the access |
| acc_wr_i | input | 1 | 1 = write, 0 = read or fetch |
| acc_cpl_i | input | 2 | Current privilege level, 0 to 3 |
| pg_present_i | input | 1 | Page present attribute |
| pg_writable_i | input | 1 | Page writable attribute |
| pg_user_i | input | 1 | Page user-accessible attribute |
| flt_o | output | 1 | Fault request pulse |
| flt_vec_o | output | 8 | Exception vector, 0x0E during a fault |
| flt_err_o | output | 32 | Error code |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 32 | Register read data |

## Verification
The fault pulse, the vector and the error code are all registered, so each one appears one cycle after the edge that samples the strobe. The fault-address register updates on that same edge. The bench drives inputs at the falling edge. At the next falling edge it compares these outputs with a reference model that holds one pending expectation from the previous cycle. The read port has no register on its path, so the bench checks it against the model's address register shortly after it sets `rd_addr_i`, within the same low phase.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int unsigned VA_W  = 32;
  localparam int unsigned ERR_W = 32;
  localparam int unsigned VEC_W = 8;
  localparam int unsigned CPL_W = 2;
  localparam logic [VEC_W-1:0] VEC_PF    = 8'h0E;
  localparam logic [CPL_W-1:0] CPL_USER  = 2'd3;

  typedef struct packed {
    logic present;
    logic writable;
    logic user;
  } pg_attr_t;

  typedef struct packed {
    logic prot;   // bit0: protection violation on present page
    logic wr;     // bit1
    logic usr;    // bit2
  } cause_t;
endpackage

// File: rtl/pfc_policy.sv
module pfc_policy
  import pfc_pkg::*;
(
  input  logic             vld_i,
  input  logic             wr_i,
  input  logic [CPL_W-1:0] cpl_i,
  input  pg_attr_t         attr_i,
  output logic             fault_o,
  output cause_t           cause_o
);
  logic usr_mode;
  logic np_viol, wp_viol, sp_viol;

  assign usr_mode = (cpl_i == CPL_USER);
  assign np_viol  = !attr_i.present;
  assign wp_viol  = attr_i.present && usr_mode && wr_i && !attr_i.writable;
  assign sp_viol  = attr_i.present && usr_mode && !attr_i.user;

  assign fault_o       = vld_i && (np_viol || wp_viol || sp_viol);
  assign cause_o.prot  = !np_viol;
  assign cause_o.wr    = wr_i;
  assign cause_o.usr   = usr_mode;

  // R5
  always_comb begin
    if (vld_i && attr_i.present && !usr_mode)
      sup_ok_chk: assert (!fault_o);
  end
endmodule

// File: rtl/pfc_err_fmt.sv
module pfc_err_fmt
  import pfc_pkg::*;
#(
  parameter int unsigned W = ERR_W
) (
  input  logic         fault_i,
  input  cause_t       cause_i,
  output logic [W-1:0] err_o
);
  localparam int unsigned PAD_W = W - 3;

  always_comb begin
    err_o = '0;
    if (fault_i) err_o = {{PAD_W{1'b0}}, cause_i.usr, cause_i.wr, cause_i.prot};
  end

  // R7
  always_comb begin
    err_hi_zero_chk: assert (err_o[W-1:3] == '0);
  end
endmodule

// File: rtl/pfc_far.sv
module pfc_far
  import pfc_pkg::*;
#(
  parameter int unsigned W = VA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] va_i,
  output logic [W-1:0] far_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   far_o <= '0;
    else if (ld_i) far_o <= va_i;
  end
endmodule

// File: rtl/pfc_top.sv
module pfc_top
  import pfc_pkg::*;
#(
  parameter int unsigned RA_W     = 2,
  parameter int unsigned FAR_ADDR = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_vld_i,
  input  logic [VA_W-1:0]  acc_va_i,
  input  logic             acc_wr_i,
  input  logic [CPL_W-1:0] acc_cpl_i,
  input  logic             pg_present_i,
  input  logic             pg_writable_i,
  input  logic             pg_user_i,
  output logic             flt_o,
  output logic [VEC_W-1:0] flt_vec_o,
  output logic [ERR_W-1:0] flt_err_o,
  input  logic [RA_W-1:0]  rd_addr_i,
  output logic [VA_W-1:0]  rd_data_o
);
  pg_attr_t         attr;
  logic             fault_d;
  cause_t           cause;
  logic [ERR_W-1:0] err_d;
  logic [VA_W-1:0]  far_q;

  assign attr = '{present: pg_present_i, writable: pg_writable_i, user: pg_user_i};

  pfc_policy u_policy (
    .vld_i   (acc_vld_i),
    .wr_i    (acc_wr_i),
    .cpl_i   (acc_cpl_i),
    .attr_i  (attr),
    .fault_o (fault_d),
    .cause_o (cause)
  );

  pfc_err_fmt #(.W(ERR_W)) u_err (
    .fault_i (fault_d),
    .cause_i (cause),
    .err_o   (err_d)
  );

  pfc_far #(.W(VA_W)) u_far (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (fault_d),
    .va_i   (acc_va_i),
    .far_o  (far_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flt_o     <= 1'b0;
      flt_vec_o <= '0;
      flt_err_o <= '0;
    end else begin
      flt_o     <= fault_d;
      flt_vec_o <= fault_d ? VEC_PF : '0;
      flt_err_o <= err_d;
    end
  end

  assign rd_data_o = (rd_addr_i == RA_W'(FAR_ADDR)) ? far_q : '0;

  // R6
  vec_on_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_o |-> flt_vec_o == VEC_PF);
  // R9
  fault_needs_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_o |-> $past(acc_vld_i));
  // R9
  quiet_err_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flt_o |-> flt_err_o == '0);
  // R8
  far_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_o |-> far_q == $past(acc_va_i));
  // R8
  far_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flt_o |-> $stable(far_q));
  // R2
  np_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_vld_i && !pg_present_i) |=> (flt_o && !flt_err_o[0]));
endmodule

// File: tb/pfc_top_tb_top.sv
module pfc_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0, wr = 1'b0, pp = 1'b0, pw = 1'b0, pu = 1'b0;
  logic [31:0] va = '0;
  logic [1:0]  cpl = '0;
  logic [1:0]  ra = '0;
  logic        flt;
  logic [7:0]  vec;
  logic [31:0] err;
  logic [31:0] rdat;

  int checks = 0, errors = 0;
  bit exp_flt = 0;
  int unsigned exp_err = 0;
  int unsigned exp_va = 0;
  int unsigned mdl_far = 0;
  string ptag = "R9";

  always #5 clk = ~clk;

  pfc_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .acc_vld_i(vld), .acc_va_i(va), .acc_wr_i(wr),
    .acc_cpl_i(cpl), .pg_present_i(pp), .pg_writable_i(pw), .pg_user_i(pu),
    .flt_o(flt), .flt_vec_o(vec), .flt_err_o(err), .rd_addr_i(ra), .rd_data_o(rdat)
  );

  task automatic chk(string tag, longint act, longint exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // compare outputs due from the previous stimulus, then update model
  task automatic check_due();
    if (exp_flt) mdl_far = exp_va;
    chk(ptag, flt, exp_flt, "fault");
    chk("R6", vec, exp_flt ? 8'h0E : 8'h00, "vector");
    chk("R7", err, exp_err, "error code");
    if (exp_flt) chk("R1", err[2], exp_err[2], "user bit");
  endtask

  // drive one access at a falling edge; then check read port; wait next negedge
  task automatic step(bit v, bit w, int c, bit p, bit wrt, bit u, int unsigned a, int r);
    bit usr, f;
    check_due();
    vld = v; wr = w; cpl = 2'(c); pp = p; pw = wrt; pu = u; va = a; ra = 2'(r);
    usr = (c == 3);
    f = v && (!p || (usr && w && !wrt) || (usr && !u));
    exp_flt = f;
    exp_va  = a;
    exp_err = f ? {29'd0, usr, w, p} : 0;
    if (!v)                 ptag = "R9";
    else if (!p)            ptag = "R2";
    else if (usr && !u)     ptag = "R4";
    else if (usr && w && !wrt) ptag = "R3";
    else                    ptag = "R5";
    #1;
    chk("R10", rdat, (r == 0) ? mdl_far : 0, "read data");
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R8", rdat, 0, "far in reset");
    chk("R9", flt, 0, "fault in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8", rdat, 0, "far after reset");
    // directed
    step(1, 0, 0, 0, 1, 1, 32'h0000_6000, 0);  // R2 sup read not present
    step(1, 1, 3, 0, 1, 1, 32'h1234_5678, 0);  // R2 user write not present
    step(1, 1, 3, 1, 0, 1, 32'hCAFE_0004, 0);  // R3
    step(1, 0, 3, 1, 1, 0, 32'hDEAD_B000, 0);  // R4 read
    step(1, 1, 3, 1, 1, 0, 32'h0BAD_0010, 1);  // R4 write
    step(1, 1, 0, 1, 0, 0, 32'h5555_0000, 0);  // R5 sup write ro
    step(1, 1, 2, 1, 0, 1, 32'h6666_0000, 0);  // R5 level 2 sup
    step(1, 0, 1, 1, 0, 0, 32'h7777_0000, 0);  // R5
    step(0, 1, 3, 0, 0, 0, 32'h8888_0000, 0);  // R9 no strobe
    step(1, 0, 3, 1, 0, 1, 32'h9999_0000, 2);  // R5 user read ro
    step(0, 0, 0, 1, 1, 1, 32'h0, 3);          // R8 hold
    step(1, 0, 2, 0, 0, 0, 32'hFFFF_F000, 0);  // R1 level 2 not user
    step(1, 0, 3, 0, 0, 0, 32'hFFFF_E000, 0);  // R1 level 3 user
    step(0, 0, 0, 1, 1, 1, 32'h0, 0);
    for (int i = 0; i < 400; i++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, $urandom_range(0, 3),
           $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
           $urandom_range(0, 1) == 1, $urandom, $urandom_range(0, 3));
    step(0, 0, 0, 1, 1, 1, 32'h0, 0);
    check_due();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule